// File: doc/BRIEF.md
# Daisy-Chained Front-End Readout Sequencer

This block controls readout for a chain of front-end chips that share one data bus. Every chip steps through four phases on common strobes: acquisition, conversion, readout and a low-power idle. A readout-start strobe creates a single token for the first chip. The token then moves along the chain, one chip at a time. While a chip holds the token, it alone drives the shared bus and sends every event it stored, one word per cycle. It then passes the token on and drops into idle. A chip that stored nothing passes the token on at once.

Each chip's event count comes from its local memory. The count is captured when readout starts. Each word on the bus carries the chip's position in the chain and the event's sequence number. The last chip's token-out pulse tells the back-end concentrator that readout of the whole chain is complete. The chain length and the width of the event counter are parameters.

Top module: `ring_readout_chain`

## Requirements
- R1: The phases are encoded on `chip_phase` as idle=0, acquisition=1, conversion=2 and readout=3, two bits per chip with chip k at bits [2k+1:2k]. The phases advance on the strobes only in this order: idle to acquisition on `stb_acq`, acquisition to conversion on `stb_conv`, conversion to readout on `stb_read`. All chips move on the same clock edge.
- R2: A strobe that does not match a chip's current phase leaves that chip's phase unchanged.
- R3: Each chip captures its field of `ev_count` (chip k at bits [k*CNT_W +: CNT_W]) on the edge that accepts `stb_read`. Later changes of `ev_count` have no effect on that readout.
- R4: Readout follows chain order, chip 0 first. Chip k with n events puts the words {k, 0} through {k, n-1} on `bus_data`, in that order. Each word is the chip index (ID_W bits) concatenated with the event index (CNT_W bits), and `bus_valid` is high for exactly those cycles.
- R5: Chip 0 takes the token on the edge after the readout strobe. A chip with n>0 events drives the bus for n consecutive cycles, starting in the cycle after it takes the token. The next chip starts driving one cycle after the last word.
- R6: A chip holding zero events raises token-out in the cycle after its token arrives and never drives the bus.
- R7: At most one bit of `bus_en` is high in any cycle. When none is high, `bus_valid` and `bus_data` are zero.
- R8: A chip returns to idle in the cycle its token-out is high. All chips are idle when `chain_done` is high.
- R9: `chain_done` is a one-cycle pulse. It is sampled high exactly D cycles after the edge that accepts `stb_read`, where D is the sum over all chips of (events + 1).
- R10: Reset puts every chip in idle and leaves no token anywhere. No bus drive or `chain_done` follows until a new phase sequence starts readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_acq | input | 1 | Acquisition start strobe |
| stb_conv | input | 1 | Conversion start strobe |
| stb_read | input | 1 | Readout start strobe; injects the token into chip 0 |
| ev_count | input | NUM_CHIPS*CNT_W | Stored event count per chip |
| bus_en | output | NUM_CHIPS | Per-chip bus drive enable |
| bus_valid | output | 1 | Shared bus carries a word |
| bus_data | output | ID_W+CNT_W | Shared bus word {chip index, event index} |
| chain_done | output | 1 | Token-out of the last chip; end of readout |
| chip_phase | output | 2*NUM_CHIPS | Current phase of every chip |

## Verification
The bench builds the chain with NUM_CHIPS=5 and CNT_W=3. A chip therefore holds zero to seven events, and one full readout takes at most 40 cycles. These small values let random count mixes reach the extreme cases often: every chip empty, every chip full, and runs of empty chips between busy ones. Many complete phase sequences fit in a short run, including changes to the counts in mid-readout, strobes given out of order, and a reset in the middle of readout.

// File: rtl/ring_ro_pkg.sv
package ring_ro_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2,
        PH_READ = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ND_WAIT = 2'd0,
        ND_SEND = 2'd1,
        ND_DONE = 2'd2
    } node_e;

    typedef struct packed {
        logic acq;
        logic conv;
        logic rd;
    } strobe_t;

    function automatic phase_e phase_step(phase_e cur, strobe_t s, logic turn_done);
        case (cur)
            PH_IDLE: return s.acq  ? PH_ACQ  : PH_IDLE;
            PH_ACQ:  return s.conv ? PH_CONV : PH_ACQ;
            PH_CONV: return s.rd   ? PH_READ : PH_CONV;
            PH_READ: return turn_done ? PH_IDLE : PH_READ;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic int unsigned id_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ring_ro_phase.sv
module ring_ro_phase
    import ring_ro_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t stb,
    input  logic    turn_done,
    output phase_e  ph,
    output logic    read_go
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE;
        end else begin
            ph <= phase_step(ph, stb, turn_done);
        end
    end

    assign read_go = (ph == PH_CONV) && stb.rd;

endmodule

// File: rtl/ring_ro_node.sv
module ring_ro_node
    import ring_ro_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int ID_W    = 3,
    parameter int CHIP_ID = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [CNT_W-1:0]      ev_count,
    input  logic                  in_read,
    input  logic                  tok_in,
    output logic                  tok_out,
    output logic                  turn_done,
    output logic                  drive,
    output logic [ID_W+CNT_W-1:0] word
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [ID_W-1:0]  MY_ID = ID_W'(CHIP_ID);

    node_e            state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic             tok_q;
    logic [CNT_W-1:0] last_idx;

    assign last_idx = cnt_q - ONE;

    always_comb begin
        turn_done = 1'b0;
        if (in_read) begin
            if (state_q == ND_WAIT && tok_in && cnt_q == ZERO) begin
                turn_done = 1'b1;
            end
            if (state_q == ND_SEND && idx_q == last_idx) begin
                turn_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ND_WAIT;
            cnt_q   <= ZERO;
            idx_q   <= ZERO;
            tok_q   <= 1'b0;
        end else begin
            tok_q <= turn_done;
            if (load) begin
                state_q <= ND_WAIT;
                cnt_q   <= ev_count;
                idx_q   <= ZERO;
            end else begin
                case (state_q)
                    ND_WAIT: begin
                        if (in_read && tok_in) begin
                            state_q <= (cnt_q == ZERO) ? ND_DONE : ND_SEND;
                            idx_q   <= ZERO;
                        end
                    end
                    ND_SEND: begin
                        if (turn_done) begin
                            state_q <= ND_DONE;
                        end else begin
                            idx_q <= idx_q + ONE;
                        end
                    end
                    default: state_q <= ND_DONE;
                endcase
            end
        end
    end

    assign tok_out = tok_q;
    assign drive   = (state_q == ND_SEND);
    assign word    = {MY_ID, idx_q};

endmodule

// File: rtl/ring_ro_bus.sv
module ring_ro_bus #(
    parameter int N = 5,
    parameter int W = 7
) (
    input  logic [N-1:0]   en,
    input  logic [N*W-1:0] words,
    output logic [W-1:0]   data,
    output logic           valid
);

    always_comb begin
        data  = '0;
        valid = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (en[k]) begin
                data  = data | words[k*W +: W];
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ring_readout_chain.sv
module ring_readout_chain
    import ring_ro_pkg::*;
#(
    parameter int NUM_CHIPS = 5,
    parameter int CNT_W     = 4,
    localparam int ID_W     = id_width(NUM_CHIPS),
    localparam int DATA_W   = ID_W + CNT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stb_acq,
    input  logic                       stb_conv,
    input  logic                       stb_read,
    input  logic [NUM_CHIPS*CNT_W-1:0] ev_count,
    output logic [NUM_CHIPS-1:0]       bus_en,
    output logic                       bus_valid,
    output logic [DATA_W-1:0]          bus_data,
    output logic                       chain_done,
    output logic [2*NUM_CHIPS-1:0]     chip_phase
);

    strobe_t                     stb;
    logic [NUM_CHIPS-1:0]        tok_in;
    logic [NUM_CHIPS-1:0]        tok_out;
    logic [NUM_CHIPS-1:0]        turn_done;
    logic [NUM_CHIPS-1:0]        read_go;
    logic [NUM_CHIPS-1:0]        drive;
    logic [NUM_CHIPS*DATA_W-1:0] words;
    phase_e                      ph [NUM_CHIPS];
    logic                        start_q;

    assign stb = '{acq: stb_acq, conv: stb_conv, rd: stb_read};

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
        end else begin
            start_q <= read_go[0];
        end
    end

    for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chip
        if (g == 0) begin : g_head
            assign tok_in[g] = start_q;
        end else begin : g_link
            assign tok_in[g] = tok_out[g-1];
        end

        ring_ro_phase u_phase (
            .clk       (clk),
            .rst       (rst),
            .stb       (stb),
            .turn_done (turn_done[g]),
            .ph        (ph[g]),
            .read_go   (read_go[g])
        );

        ring_ro_node #(
            .CNT_W   (CNT_W),
            .ID_W    (ID_W),
            .CHIP_ID (g)
        ) u_node (
            .clk       (clk),
            .rst       (rst),
            .load      (read_go[g]),
            .ev_count  (ev_count[g*CNT_W +: CNT_W]),
            .in_read   (ph[g] == PH_READ),
            .tok_in    (tok_in[g]),
            .tok_out   (tok_out[g]),
            .turn_done (turn_done[g]),
            .drive     (drive[g]),
            .word      (words[g*DATA_W +: DATA_W])
        );

        assign chip_phase[2*g +: 2] = ph[g];
    end

    ring_ro_bus #(
        .N (NUM_CHIPS),
        .W (DATA_W)
    ) u_bus (
        .en    (drive),
        .words (words),
        .data  (bus_data),
        .valid (bus_valid)
    );

    assign bus_en     = drive;
    assign chain_done = tok_out[NUM_CHIPS-1];

endmodule

// File: rtl/ring_readout_chain_chk.sv
module ring_readout_chain_chk #(
    parameter int N      = 5,
    parameter int DATA_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              stb_acq,
    input logic              stb_conv,
    input logic [N-1:0]      bus_en,
    input logic              bus_valid,
    input logic [DATA_W-1:0] bus_data,
    input logic              chain_done,
    input logic [2*N-1:0]    chip_phase
);

    a_r7_single_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_en));

    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        (bus_en == '0) |-> (!bus_valid && bus_data == '0));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        chain_done |=> !chain_done);

    a_r8_done_all_idle: assert property (@(posedge clk) disable iff (rst)
        chain_done |-> (chip_phase == '0));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (chip_phase[1:0] == 2'd0 && !stb_acq) |=> (chip_phase[1:0] == 2'd0));

    a_r1_conv_entry: assert property (@(posedge clk) disable iff (rst)
        (chip_phase[1:0] == 2'd1 && stb_conv) |=> (chip_phase[1:0] == 2'd2));

    a_r5_drive_in_read: assert property (@(posedge clk) disable iff (rst)
        bus_en[0] |-> (chip_phase[1:0] == 2'd3));

endmodule

bind ring_readout_chain ring_readout_chain_chk #(
    .N      (NUM_CHIPS),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/ring_readout_chain_tb.sv
module ring_readout_chain_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 5;
    localparam int CW = 3;
    localparam int IW = 3;
    localparam int DW = IW + CW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             stb_acq = 1'b0;
    logic             stb_conv = 1'b0;
    logic             stb_read = 1'b0;
    logic [NC*CW-1:0] ev_count = '0;
    logic [NC-1:0]    bus_en;
    logic             bus_valid;
    logic [DW-1:0]    bus_data;
    logic             chain_done;
    logic [2*NC-1:0]  chip_phase;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit      exp_v [64];
    int      exp_d [64];

    ring_readout_chain #(.NUM_CHIPS(NC), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .stb_acq(stb_acq), .stb_conv(stb_conv),
        .stb_read(stb_read), .ev_count(ev_count), .bus_en(bus_en),
        .bus_valid(bus_valid), .bus_data(bus_data), .chain_done(chain_done),
        .chip_phase(chip_phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int all_phase(input int p);
        int v = 0;
        for (int k = 0; k < NC; k++) v = v | (p << (2*k));
        return v;
    endfunction

    function automatic int word_of(input int chip, input int ev);
        return (chip << CW) | ev;
    endfunction

    task automatic strobe(input int which);
        @(negedge clk);
        stb_acq  = (which == 0);
        stb_conv = (which == 1);
        stb_read = (which == 2);
        @(negedge clk);
        stb_acq = 1'b0; stb_conv = 1'b0; stb_read = 1'b0;
    endtask

    task automatic run_readout(input int n [NC], input bit perturb);
        int t;
        int dur;
        bit zero_all;
        zero_all = 1'b1;
        for (int k = 0; k < NC; k++) begin
            ev_count[k*CW +: CW] = CW'(n[k]);
            if (n[k] != 0) zero_all = 1'b0;
        end
        for (int c = 0; c < 64; c++) begin exp_v[c] = 1'b0; exp_d[c] = 0; end
        t = 1;
        for (int k = 0; k < NC; k++) begin
            for (int e = 0; e < n[k]; e++) begin
                exp_v[t+e] = 1'b1;
                exp_d[t+e] = word_of(k, e);
            end
            t = t + n[k] + 1;
        end
        dur = t - 1;
        strobe(0);
        check(chip_phase == all_phase(1), "R1", "phase after acq", chip_phase, all_phase(1));
        strobe(1);
        check(chip_phase == all_phase(2), "R1", "phase after conv", chip_phase, all_phase(2));
        strobe(2);
        check(chip_phase == all_phase(3), "R1", "phase after read", chip_phase, all_phase(3));
        for (int c = 1; c <= dur + 2; c++) begin
            @(negedge clk);
            if (perturb && c == 1) ev_count = NC*CW'($urandom);
            check(bus_valid == exp_v[c], "R5", "valid timing", bus_valid, exp_v[c]);
            if (exp_v[c]) check(int'(bus_data) == exp_d[c], "R4", "bus word",
                                bus_data, exp_d[c]);
            check($countones(bus_en) <= 1, "R7", "drivers", $countones(bus_en), 1);
            if (zero_all)
                check(chain_done == (c == dur), "R6", "empty chain done", chain_done, c == dur);
            else
                check(chain_done == (c == dur), "R9", "done timing", chain_done, c == dur);
            if (c == dur)
                check(chip_phase == 0, "R8", "idle at done", chip_phase, 0);
        end
        if (perturb)
            check(1'b1, "R3", "count changes ignored (covered by R4 words)", 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(chip_phase == 0, "R10", "reset phase", chip_phase, 0);
        check(bus_en == 0 && !bus_valid, "R10", "reset bus", bus_en, 0);
        check(!chain_done, "R10", "reset done", chain_done, 0);

        strobe(1);
        check(chip_phase == 0, "R2", "conv from idle", chip_phase, 0);
        strobe(2);
        check(chip_phase == 0, "R2", "read from idle", chip_phase, 0);
        repeat (4) begin
            @(negedge clk);
            check(!bus_valid && !chain_done, "R2", "no token from stray read",
                  bus_valid, 0);
        end
        strobe(0);
        check(chip_phase == all_phase(1), "R1", "acq entry", chip_phase, all_phase(1));
        strobe(2);
        check(chip_phase == all_phase(1), "R2", "read from acq", chip_phase, all_phase(1));
        strobe(0);
        check(chip_phase == all_phase(1), "R2", "acq twice", chip_phase, all_phase(1));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(chip_phase == 0, "R10", "reset from acq", chip_phase, 0);

        run_readout('{0, 0, 0, 0, 0}, 1'b0);
        run_readout('{7, 7, 7, 7, 7}, 1'b0);
        run_readout('{0, 0, 0, 0, 5}, 1'b1);
        run_readout('{3, 0, 2, 0, 1}, 1'b1);
        run_readout('{1, 1, 1, 1, 1}, 1'b0);

        for (int r = 0; r < 30; r++) begin
            int n [NC];
            for (int k = 0; k < NC; k++) n[k] = $urandom_range(0, 7);
            if (r % 5 == 0) n[$urandom_range(0, NC-1)] = 0;
            run_readout(n, r[0]);
        end

        ev_count = '1;
        strobe(0); strobe(1); strobe(2);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(chip_phase == 0 && bus_en == 0, "R10", "reset mid-readout", chip_phase, 0);
        for (int c = 0; c < 45; c++) begin
            @(negedge clk);
            check(!bus_valid && !chain_done, "R10", "no token after reset",
                  {bus_valid, chain_done}, 0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule